// File: doc/BRIEF.md
# Instruction Control Decoder

This block is the combinational control decoder of a simple single-cycle 32-bit processor core. It takes the primary opcode field and the function field of the instruction being executed, together with the equality flag that the ALU reports. From these it produces every steering and enable signal the datapath needs for that instruction:
- destination register choice
- register write enable
- ALU operand-B source
- a 3-bit ALU operation select
- data memory write and read strobes
- write-back source
- whether the next fetch address is the branch target

Four instruction groups are decoded: register-register arithmetic (add, subtract, AND, OR, set-less-than), word load, word store and branch-if-equal. Any other encoding is treated as a harmless bubble. A bubble writes no register, touches no memory and does not redirect the fetch address. Every output that is don't-care for an instruction group is driven to 0, so each input pattern has exactly one valid output vector.

Because the decoder folds the ALU flag into the branch decision itself, the surrounding datapath only needs a 2-way multiplexer on the next-PC path. It needs no separate branch gate.

Top module: `insn_ctl_decoder`

## Requirements
- R1: Opcode 000000 with a recognised function code gives dst_rd_o=1, reg_we_o=1, alu_imm_o=0, mem_we_o=0, mem_re_o=0 and wb_mem_o=0.
- R2: For opcode 000000, the function code sets alu_sel_o as follows: 100000 gives 010 (add), 100010 gives 110 (subtract), 100100 gives 000 (AND), 100101 gives 001 (OR) and 101010 gives 111 (set-less-than).
- R3: Opcode 100011 (load) gives dst_rd_o=0, reg_we_o=1, alu_imm_o=1, alu_sel_o=010, mem_we_o=0, mem_re_o=1 and wb_mem_o=1, for any function code.
- R4: Opcode 101011 (store) gives reg_we_o=0, alu_imm_o=1, alu_sel_o=010, mem_we_o=1 and mem_re_o=0, with dst_rd_o=0 and wb_mem_o=0, for any function code.
- R5: Opcode 000100 (branch-if-equal) gives reg_we_o=0, alu_imm_o=0, alu_sel_o=110, mem_we_o=0, mem_re_o=0, dst_rd_o=0 and wb_mem_o=0, for any function code.
- R6: br_take_o is 1 exactly when the opcode is 000100 and alu_zero_i is 1. alu_zero_i has no effect on any other output.
- R7: Any opcode other than the four listed drives all ten output bits to 0.
- R8: Opcode 000000 with a function code outside the five listed drives all ten output bits to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 6 | Primary opcode field of the instruction |
| funct_i | input | 6 | Function field of the instruction |
| alu_zero_i | input | 1 | ALU result-is-zero flag |
| dst_rd_o | output | 1 | 1 selects the rd field as destination, 0 selects rt |
| reg_we_o | output | 1 | Register file write enable |
| alu_imm_o | output | 1 | 1 feeds the sign-extended immediate to ALU operand B |
| alu_sel_o | output | 3 | ALU operation select |
| mem_we_o | output | 1 | Data memory write strobe |
| mem_re_o | output | 1 | Data memory read strobe |
| wb_mem_o | output | 1 | 1 writes memory data back, 0 writes the ALU result |
| br_take_o | output | 1 | 1 loads the branch target into the PC |

## Verification
The block holds no state, so a wrong internal decision shows up at the ports in the same cycle as the input pattern that causes it. A misclassified opcode shows as a wrong enable vector. A wrong function mapping shows as a wrong alu_sel_o code. A leak of the zero flag shows as br_take_o or another output changing with alu_zero_i alone. The bench sweeps every opcode and function code pair with both flag values, which covers the whole 13-bit input space.

// File: rtl/insn_ctl_pkg.sv
package insn_ctl_pkg;

  localparam int OPC_W = 6;
  localparam int FN_W  = 6;
  localparam int SEL_W = 3;

  typedef enum logic [2:0] {
    CLS_BUBBLE = 3'd0,
    CLS_ARITH  = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_STORE  = 3'd3,
    CLS_BRANCH = 3'd4
  } insn_cls_e;

  localparam logic [SEL_W-1:0] SEL_AND = 3'b000;
  localparam logic [SEL_W-1:0] SEL_OR  = 3'b001;
  localparam logic [SEL_W-1:0] SEL_ADD = 3'b010;
  localparam logic [SEL_W-1:0] SEL_SUB = 3'b110;
  localparam logic [SEL_W-1:0] SEL_SLT = 3'b111;

  localparam logic [OPC_W-1:0] OPC_ARITH  = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 6'b000100;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_AND = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

  typedef struct packed {
    logic             dst_rd;
    logic             reg_we;
    logic             alu_imm;
    logic [SEL_W-1:0] alu_sel;
    logic             mem_we;
    logic             mem_re;
    logic             wb_mem;
    logic             br_take;
  } ctl_word_t;

  // Function field lookup: returns {valid, select}
  function automatic logic [SEL_W:0] fn_to_sel(input logic [FN_W-1:0] fn);
    logic [SEL_W:0] r;
    unique case (fn)
      FN_ADD:  r = {1'b1, SEL_ADD};
      FN_SUB:  r = {1'b1, SEL_SUB};
      FN_AND:  r = {1'b1, SEL_AND};
      FN_OR:   r = {1'b1, SEL_OR};
      FN_SLT:  r = {1'b1, SEL_SLT};
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/insn_cls_dec.sv
module insn_cls_dec
  import insn_ctl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             fn_ok_i,
  output insn_cls_e        cls_o
);
  always_comb begin
    unique case (opcode_i)
      OPC_ARITH:  cls_o = fn_ok_i ? CLS_ARITH : CLS_BUBBLE;
      OPC_LOAD:   cls_o = CLS_LOAD;
      OPC_STORE:  cls_o = CLS_STORE;
      OPC_BRANCH: cls_o = CLS_BRANCH;
      default:    cls_o = CLS_BUBBLE;
    endcase
  end
endmodule

// File: rtl/alu_sel_dec.sv
module alu_sel_dec
  import insn_ctl_pkg::*;
(
  input  logic [FN_W-1:0]  funct_i,
  input  insn_cls_e        cls_i,
  output logic             fn_ok_o,
  output logic [SEL_W-1:0] sel_o
);
  logic [SEL_W:0] fn_lookup;

  assign fn_lookup = fn_to_sel(funct_i);
  assign fn_ok_o   = fn_lookup[SEL_W];

  always_comb begin
    unique case (cls_i)
      CLS_ARITH:            sel_o = fn_lookup[SEL_W-1:0];
      CLS_LOAD, CLS_STORE:  sel_o = SEL_ADD;
      CLS_BRANCH:           sel_o = SEL_SUB;
      default:              sel_o = SEL_AND;
    endcase
  end
endmodule

// File: rtl/ctl_route.sv
module ctl_route
  import insn_ctl_pkg::*;
(
  input  insn_cls_e        cls_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             zero_i,
  output ctl_word_t        ctl_o
);
  always_comb begin
    ctl_o = '0;
    unique case (cls_i)
      CLS_ARITH: begin
        ctl_o.dst_rd = 1'b1;
        ctl_o.reg_we = 1'b1;
        ctl_o.alu_sel = sel_i;
      end
      CLS_LOAD: begin
        ctl_o.reg_we  = 1'b1;
        ctl_o.alu_imm = 1'b1;
        ctl_o.alu_sel = sel_i;
        ctl_o.mem_re  = 1'b1;
        ctl_o.wb_mem  = 1'b1;
      end
      CLS_STORE: begin
        ctl_o.alu_imm = 1'b1;
        ctl_o.alu_sel = sel_i;
        ctl_o.mem_we  = 1'b1;
      end
      CLS_BRANCH: begin
        ctl_o.alu_sel = sel_i;
        ctl_o.br_take = zero_i;
      end
      default: ctl_o = '0;
    endcase
  end

  // R4: a memory access is either a read or a write, never both
  always_comb begin
    p_mem_excl_r4: assert (!(ctl_o.mem_we && ctl_o.mem_re))
      else $error("mem strobes both high");
  end

  // R6: taking the branch needs the branch class and the zero flag
  always_comb begin
    p_branch_gate_r6: assert (!ctl_o.br_take || (cls_i == CLS_BRANCH && zero_i))
      else $error("branch taken without beq and zero");
  end
endmodule

// File: rtl/insn_ctl_decoder.sv
module insn_ctl_decoder
  import insn_ctl_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  input  logic       alu_zero_i,
  output logic       dst_rd_o,
  output logic       reg_we_o,
  output logic       alu_imm_o,
  output logic [2:0] alu_sel_o,
  output logic       mem_we_o,
  output logic       mem_re_o,
  output logic       wb_mem_o,
  output logic       br_take_o
);
  insn_cls_e        cls;
  logic             fn_ok;
  logic [SEL_W-1:0] sel;
  ctl_word_t        ctl;

  alu_sel_dec u_sel (
    .funct_i (funct_i),
    .cls_i   (cls),
    .fn_ok_o (fn_ok),
    .sel_o   (sel)
  );

  insn_cls_dec u_cls (
    .opcode_i (opcode_i),
    .fn_ok_i  (fn_ok),
    .cls_o    (cls)
  );

  ctl_route u_route (
    .cls_i  (cls),
    .sel_i  (sel),
    .zero_i (alu_zero_i),
    .ctl_o  (ctl)
  );

  assign dst_rd_o  = ctl.dst_rd;
  assign reg_we_o  = ctl.reg_we;
  assign alu_imm_o = ctl.alu_imm;
  assign alu_sel_o = ctl.alu_sel;
  assign mem_we_o  = ctl.mem_we;
  assign mem_re_o  = ctl.mem_re;
  assign wb_mem_o  = ctl.wb_mem;
  assign br_take_o = ctl.br_take;

  // R7: an unknown opcode produces a fully quiet control word
  always_comb begin
    p_bubble_quiet_r7: assert (!(cls == CLS_BUBBLE) || ctl == '0)
      else $error("bubble not quiet");
  end

  // R3: a load always computes its address with an add
  always_comb begin
    p_load_add_r3: assert (!(opcode_i == OPC_LOAD) || (alu_sel_o == SEL_ADD && mem_re_o))
      else $error("load select wrong");
  end

  // R8: an arithmetic op with an unknown function code never writes a register
  always_comb begin
    p_bad_fn_nowrite_r8: assert (fn_ok || opcode_i != OPC_ARITH || !reg_we_o)
      else $error("bad function writes register");
  end
endmodule

// File: tb/tb_insn_ctl_decoder.sv
module tb_insn_ctl_decoder;
  logic       clk = 1'b0;
  logic [5:0] opcode;
  logic [5:0] funct;
  logic       zero;
  logic       dst_rd, reg_we, alu_imm, mem_we, mem_re, wb_mem, br_take;
  logic [2:0] alu_sel;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  insn_ctl_decoder dut (
    .opcode_i(opcode), .funct_i(funct), .alu_zero_i(zero),
    .dst_rd_o(dst_rd), .reg_we_o(reg_we), .alu_imm_o(alu_imm),
    .alu_sel_o(alu_sel), .mem_we_o(mem_we), .mem_re_o(mem_re),
    .wb_mem_o(wb_mem), .br_take_o(br_take)
  );

  // Output order: dst, we, imm, sel[2:0], mwe, mre, wbm, br
  function automatic logic [9:0] model(input logic [5:0] op, input logic [5:0] fn,
                                       input logic z);
    logic [2:0] s;
    logic ok;
    ok = 1'b1;
    s  = 3'b000;
    if (op == 6'd0) begin
      // R2: list of function codes and their selects
      if      (fn == 6'd32) s = 3'd2;
      else if (fn == 6'd34) s = 3'd6;
      else if (fn == 6'd36) s = 3'd0;
      else if (fn == 6'd37) s = 3'd1;
      else if (fn == 6'd42) s = 3'd7;
      else ok = 1'b0;
      return ok ? {2'b11, 1'b0, s, 4'b0000} : 10'd0;
    end
    if (op == 6'd35) return {3'b011, 3'd2, 4'b0110};
    if (op == 6'd43) return {3'b001, 3'd2, 4'b1000};
    if (op == 6'd4)  return {3'b000, 3'd6, 3'b000, z};
    return 10'd0;
  endfunction

  function automatic string req_of(input logic [5:0] op, input logic [5:0] fn);
    if (op == 6'd0)  return (model(op, fn, 1'b0) == 10'd0) ? "R8" : "R1/R2";
    if (op == 6'd35) return "R3";
    if (op == 6'd43) return "R4";
    if (op == 6'd4)  return "R5/R6";
    return "R7";
  endfunction

  task automatic check(input logic [5:0] op, input logic [5:0] fn, input logic z,
                       input string tag);
    logic [9:0] act, exp;
    @(negedge clk);
    opcode = op; funct = fn; zero = z;
    #2;
    act = {dst_rd, reg_we, alu_imm, alu_sel, mem_we, mem_re, wb_mem, br_take};
    exp = model(op, fn, z);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%b fn=%b z=%b actual=%b expected=%b",
               tag, op, fn, z, act, exp);
    end
  endtask

  initial begin
    opcode = '0; funct = '0; zero = 1'b0;
    // Start pattern: all-zero word is an unknown function, R8 quiet
    check(6'd0, 6'd0, 1'b0, "R8");
    // Directed corners
    check(6'd4, 6'd0, 1'b1, "R6");
    check(6'd4, 6'd0, 1'b0, "R6");
    check(6'd35, 6'd63, 1'b1, "R3");
    check(6'd43, 6'd32, 1'b1, "R4");
    check(6'd0, 6'd42, 1'b1, "R2");
    check(6'd63, 6'd32, 1'b1, "R7");
    // Exhaustive sweep of the 13-bit input space
    for (int o = 0; o < 64; o++)
      for (int f = 0; f < 64; f++)
        for (int z = 0; z < 2; z++)
          check(o[5:0], f[5:0], z[0], req_of(o[5:0], f[5:0]));
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule